// File: doc/BRIEF.md
# Length-prefixed Ethernet transmit FIFO

This block takes an outgoing Ethernet frame from a host that writes 32-bit words into a single data register. The words fill a 2048-byte buffer, least significant byte first. The first word of each frame carries the payload length in its low half. That length does not count the 14 header bytes. After every accepted data write, the block evaluates two conditions. The first is a fill threshold, set in units of words. The second is a completeness test derived from the length. When both pass, the block drains the frame as a byte stream on a valid/ready output.

A host that does not use the threshold can force a send with a transmit request strobe. Short frames can optionally be padded with zeros up to the minimum frame size. Two sticky flags report status:

- An error flag marks an oversized length word.
- An empty flag marks a completed send.

Both flags are cleared by writing ones to an acknowledge register.

Top module: `lpfx_tx_fifo`

## Requirements
- R1: After reset the fill count is 0, both flags are low, no byte is offered, and the threshold register holds 63, which disables automatic sending.
- R2: A data write while the fill is 0 whose low 16 bits exceed 2032 is not stored and sets the error flag `tx_err`. The fill stays 0.
- R3: Each accepted data write adds 4 bytes, stored least significant byte first at the current fill. A write that would make the fill exceed 2048 is discarded, and the fill holds at 2048.
- R4: A frame is complete when the fill is at least length+16. It is length+20 when the auto-CRC bit (bit 2 of the control register) is 0. This requirement is capped at 2048.
- R5: The threshold check is active only for a threshold value below 63. It passes when the fill is at least 32*thr+4. After a data write, a send starts automatically when both the threshold check and the completeness test pass.
- R6: Writing a value with bit 0 set to the send-request register (select 4) starts a send of the current buffer contents.
- R7: A sent frame is made of buffer bytes starting at byte offset 2. Its length is length+14, capped at 2046. `tx_last` marks its final byte.
- R8: When the pad bit (bit 1 of the control register) is 1 and length+14 is below 60, zero bytes follow the frame until it is 60 bytes long.
- R9: When the last byte is accepted, the fill returns to 0 and the empty flag `tx_empty` is set. Writing to the acknowledge register (select 3) clears the flags:
  - Bit 0 clears `tx_err` and also clears the fill.
  - Bit 1 clears `tx_empty`.
- R10: While a frame streams, `busy` is high and data writes are ignored. A byte that is offered is held stable until `tx_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 data, 1 control, 2 threshold, 3 acknowledge, 4 send request |
| wr_data | input | 32 | Write data |
| busy | output | 1 | A frame is streaming; data writes are ignored |
| fill_o | output | 12 | Bytes held in the buffer |
| tx_err | output | 1 | Sticky oversized-length flag |
| tx_empty | output | 1 | Sticky send-complete flag |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
A wrong fill count shows at the ports in the cycle after the write that caused it. It can also show through the send decision: a frame starts one word early or late, or never starts. A wrong length capture or wrong byte addressing corrupts the very first streamed byte or shifts where `tx_last` falls, so a full-frame comparison exposes it within one frame. Errors in the padding or the caps appear only at the frame tail, which is why directed frames of 2032 bytes and very short frames are driven alongside the random ones.

// File: rtl/lpfx_tx_fifo.sv
module lpfx_tx_fifo #(
  parameter int DEPTH  = 2048,
  parameter int MAXLEN = 2032,
  parameter int PADLEN = 60,
  parameter int HDR    = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic        busy,
  output logic [11:0] fill_o,
  output logic        tx_err,
  output logic        tx_empty,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam int WORDS = DEPTH / 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = AW + 1;

  logic [31:0]   mem [WORDS];
  logic [FW-1:0] fill;
  logic [5:0]    thr;
  logic          pad_en, crc_en, sending;
  logic [AW-1:0] idx, out_len, raw_len;

  logic          data_wr, len_bad, accept, auto_go, man_go, go, thr_ok;
  logic [FW:0]   fill_p4;
  logic [FW-1:0] fill_n, need, thr_lim;
  logic [15:0]   cur_len;
  logic [16:0]   need_raw, raw_w;
  logic [AW-1:0] raw_n, len_n, rd_a;
  logic [31:0]   rd_w;

  assign data_wr  = wr_en && wr_sel == 3'd0 && !sending;
  assign len_bad  = fill == '0 && wr_data[15:0] > 16'(MAXLEN);
  assign fill_p4  = {1'b0, fill} + (FW+1)'(4);
  assign accept   = data_wr && !len_bad && fill_p4 <= (FW+1)'(DEPTH);
  assign fill_n   = accept ? fill_p4[FW-1:0] : fill;
  assign cur_len  = (fill == '0 && accept) ? wr_data[15:0] : mem[0][15:0];

  assign need_raw = {1'b0, cur_len} + (crc_en ? 17'd16 : 17'd20);
  assign need     = (need_raw > 17'(DEPTH)) ? FW'(DEPTH) : need_raw[FW-1:0];
  assign thr_lim  = FW'({thr, 5'b0}) + FW'(4);
  assign thr_ok   = thr != 6'h3f && fill_n >= thr_lim;
  assign auto_go  = data_wr && !len_bad && thr_ok && fill_n >= need;
  assign man_go   = wr_en && wr_sel == 3'd4 && wr_data[0] && !sending;
  assign go       = auto_go || man_go;

  assign raw_w    = {1'b0, cur_len} + 17'(HDR);
  assign raw_n    = (raw_w > 17'(DEPTH - 2)) ? AW'(DEPTH - 2) : raw_w[AW-1:0];
  assign len_n    = (pad_en && raw_n < AW'(PADLEN)) ? AW'(PADLEN) : raw_n;

  assign rd_a     = idx + AW'(2);
  assign rd_w     = mem[rd_a[AW-1:2]];
  assign tx_data  = (idx >= raw_len) ? 8'h00 : rd_w[8*rd_a[1:0] +: 8];
  assign tx_valid = sending;
  assign tx_last  = sending && idx == out_len - AW'(1);
  assign busy     = sending;
  assign fill_o   = 12'(fill);

  always_ff @(posedge clk)
    if (accept) mem[fill[AW-1:2]] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill     <= '0;
      thr      <= 6'h3f;
      pad_en   <= 1'b0;
      crc_en   <= 1'b0;
      sending  <= 1'b0;
      idx      <= '0;
      out_len  <= '0;
      raw_len  <= '0;
      tx_err   <= 1'b0;
      tx_empty <= 1'b0;
    end else begin
      fill <= fill_n;
      if (data_wr && len_bad) tx_err <= 1'b1;
      if (wr_en && wr_sel == 3'd1) begin
        pad_en <= wr_data[1];
        crc_en <= wr_data[2];
      end
      if (wr_en && wr_sel == 3'd2) thr <= wr_data[5:0];
      if (wr_en && wr_sel == 3'd3) begin
        if (wr_data[0]) begin
          tx_err <= 1'b0;
          fill   <= '0;
        end
        if (wr_data[1]) tx_empty <= 1'b0;
      end
      if (go) begin
        sending <= 1'b1;
        idx     <= '0;
        out_len <= len_n;
        raw_len <= raw_n;
      end else if (sending && tx_ready) begin
        if (tx_last) begin
          sending  <= 1'b0;
          fill     <= '0;
          tx_empty <= 1'b1;
        end else begin
          idx <= idx + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lpfx_tx_fifo_chk.sv
module lpfx_tx_fifo_chk #(
  parameter int DEPTH  = 2048,
  parameter int MAXLEN = 2032,
  parameter int PADLEN = 60,
  parameter int HDR    = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic        busy,
  input logic [11:0] fill_o,
  input logic        tx_err,
  input logic        tx_empty,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        tx_ready
);
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill_o) <= DEPTH && fill_o[1:0] == 2'b00);

  a_r10_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r9_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> fill_o == 12'd0 && tx_empty && !busy);

  a_r10_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && wr_sel == 3'd0 && !(tx_ready && tx_last) |=> $stable(fill_o));

  a_r2_reject_len: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 3'd0 && !busy && fill_o == 12'd0 && 32'(wr_data[15:0]) > MAXLEN
    |=> tx_err && fill_o == 12'd0);

  a_r7_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
endmodule

bind lpfx_tx_fifo lpfx_tx_fifo_chk #(.DEPTH(DEPTH), .MAXLEN(MAXLEN), .PADLEN(PADLEN), .HDR(HDR)) u_chk (.*);

// File: tb/lpfx_tx_fifo_tb.sv
module lpfx_tx_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tx_ready = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic busy, tx_err, tx_empty, tx_valid, tx_last;
  logic [11:0] fill_o;
  logic [7:0]  tx_data;

  lpfx_tx_fifo u_dut (.clk, .rst_n, .wr_en, .wr_sel, .wr_data, .busy, .fill_o,
    .tx_err, .tx_empty, .tx_valid, .tx_data, .tx_last, .tx_ready);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mbuf [2048];
  int  mfill = 0, mthr = 63;
  bit  mpad = 0, mcrc = 0, merr = 0, memp = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mlen();
    return int'(mbuf[0]) | (int'(mbuf[1]) << 8);
  endfunction

  function automatic int raw_len();
    int r = mlen() + 14;
    return (r > 2046) ? 2046 : r;
  endfunction

  function automatic int frame_len();
    int r = raw_len();
    return (mpad && r < 60) ? 60 : r;
  endfunction

  function automatic int exp_byte(input int i);
    return (i >= raw_len()) ? 0 : int'(mbuf[i + 2]);
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setcfg(input bit pad, input bit crc, input int thr);
    wr(3'd1, {29'd0, crc, pad, 1'b0});
    wr(3'd2, 32'(thr));
    mpad = pad; mcrc = crc; mthr = thr;
  endtask

  task automatic data_word(input logic [31:0] d, output bit sent);
    int need;
    sent = 0;
    if (mfill == 0 && d[15:0] > 16'd2032) begin
      merr = 1;
    end else begin
      if (mfill + 4 <= 2048) begin
        for (int k = 0; k < 4; k++) mbuf[mfill + k] = d[8*k +: 8];
        mfill += 4;
      end
      need = mlen() + (mcrc ? 16 : 20);
      if (need > 2048) need = 2048;
      sent = (mthr < 63) && (mfill >= 32*mthr + 4) && (mfill >= need);
    end
    wr(3'd0, d);
  endtask

  task automatic collect(input string tag);
    int n = frame_len(), i = 0, bad = 0, guard = 0;
    bit done = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      tx_ready = ($urandom % 4) != 0;
      if (tx_valid && tx_ready) begin
        if (bad == 0 && (int'(tx_data) != exp_byte(i) || tx_last != (i == n - 1))) begin
          $display("byte %0d mismatch in %s", i, tag);
          check(0, tag, int'(tx_data), exp_byte(i));
          bad++;
        end
        if (tx_last) done = 1;
        i++;
      end
    end
    @(negedge clk);
    tx_ready = 1'b0;
    check(i == n, {tag, " length"}, i, n);
    check(fill_o == 12'd0 && tx_empty, "R9 fill cleared and empty set", int'(fill_o), 0);
    mfill = 0; memp = 1;
  endtask

  task automatic frame(input int len, input int words, input bit manual, input string tag);
    bit sent = 0;
    for (int w = 0; w < words && !sent; w++) begin
      data_word((w == 0) ? {$urandom % 65536, len[15:0]} : $urandom, sent);
      check(tx_valid == sent, "R5 auto send decision", int'(tx_valid), int'(sent));
      check(int'(fill_o) == (sent ? fill_o : mfill), "R3 fill count", int'(fill_o), mfill);
    end
    if (!sent && manual) wr(3'd4, 32'd1);
    if (sent || manual) collect(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit s;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(fill_o == 0 && !tx_err && !tx_empty && !tx_valid && !busy, "R1 reset state", int'(fill_o), 0);

    // R1: threshold 63 after reset keeps a complete frame from starting
    mcrc = 0;
    frame(10, 8, 0, "R1");
    check(!tx_valid && fill_o == 32, "R1 no auto send at reset threshold", int'(fill_o), 32);
    wr(3'd4, 32'd1);
    collect("R6 manual send frame");
    wr(3'd3, 32'd2);
    check(!tx_empty, "R9 ack clears empty", int'(tx_empty), 0);

    // R4 completeness with and without auto CRC, R5 threshold 0
    setcfg(0, 1, 0);
    frame(10, 20, 0, "R4 complete with crc");
    setcfg(0, 0, 0);
    frame(10, 20, 0, "R4 complete without crc");
    setcfg(0, 1, 2);
    frame(10, 30, 0, "R5 threshold gate");

    // R8 padding
    setcfg(1, 1, 0);
    frame(6, 20, 0, "R8 padded frame");
    setcfg(0, 1, 0);
    frame(6, 20, 0, "R7 short unpadded frame");

    // R2 oversized length
    data_word(32'h0000_07f1, s);
    check(tx_err && fill_o == 0, "R2 oversized length rejected", int'(tx_err), 1);
    wr(3'd3, 32'd1);
    check(!tx_err, "R9 ack clears error", int'(tx_err), 0);

    // R9 ack bit 0 clears fill
    setcfg(0, 1, 63);
    frame(100, 5, 0, "R9 partial");
    wr(3'd3, 32'd1); mfill = 0;
    check(fill_o == 0, "R9 ack clears fill", int'(fill_o), 0);

    // R3 overflow discard and R7 cap, then R4 cap with auto send
    setcfg(0, 0, 63);
    frame(2032, 513, 0, "R3 fill to limit");
    check(fill_o == 2048, "R3 extra write discarded", int'(fill_o), 2048);
    wr(3'd4, 32'd1);
    collect("R7 capped frame");
    setcfg(0, 0, 0);
    frame(2032, 513, 0, "R4 capped completeness");

    // R10 data write while busy
    setcfg(0, 1, 63);
    frame(20, 4, 0, "R10 load");
    wr(3'd4, 32'd1);
    check(busy && tx_valid, "R10 busy while streaming", int'(busy), 1);
    wr(3'd0, 32'hdead_beef);
    check(fill_o == 16 && busy, "R10 data write ignored", int'(fill_o), 16);
    collect("R10 frame unchanged");

    // random frames
    for (int f = 0; f < 30; f++) begin
      int len = $urandom % 200;
      int thrs [5] = '{0, 1, 3, 7, 63};
      setcfg(bit'($urandom % 2), bit'($urandom % 2), thrs[$urandom % 5]);
      frame(len, (len + 20) / 4 + 1 + ($urandom % 3), 1, "R7 random frame");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule